// File: doc/BRIEF.md
# Polyphase scaling coefficient loader

This block fills a polyphase filter's coefficient memory for one image dimension at a time. A single-cycle `start` pulse hands it a direction (horizontal or vertical), a source size and a destination size. From these it picks one of ten coefficient sets held in a built-in ROM. It then writes that set, row by row, into the coefficient memory through a plain write port. When the last word is written, it pulses `done` and raises a per-direction pending flag. The filter datapath holds that flag until it acknowledges the new coefficients.

Set selection goes by the scaling ratio. An enlargement takes the up-scale set. Equal sizes take a unity set. A reduction measures the ratio in sixteenths with integer division, performed by a small sequential restoring divider, and clamps it at eight. In horizontal mode the destination width is doubled up to twice before the ratio is taken, which accounts for the two-times and four-times decimation stages ahead of the filter. Each memory row is laid out on an aligned stride. The slots after the last tap of a row are never written.

The ROM contents are placeholders. Each word encodes where it came from, so the copy order and the set choice can be seen at the write port.

Top module: `coeff_loader`

## Requirements
- R1: When the destination size is greater than the source size, set 0 (up-scale) is selected, in both modes.
- R2: In horizontal mode (`mode_v`=0) the destination width is doubled if twice its value is below the source width, and that test is applied a second time, so it is doubled at most twice before the set is chosen.
- R3: When the (adjusted) destination size equals the source size, set 1 is selected (unity in horizontal mode, 1:1 in vertical mode).
- R4: Otherwise s = floor(dst*16/src), raised to 8 if it is below 8, and the set is 2 + (s - 8), giving sets 2..9.
- R5: In vertical mode (`mode_v`=1) the destination height is used unchanged in the ratio.
- R6: A copy writes 2*NUM_PHASES = 16 rows of 7 words (horizontal) or 5 words (vertical), in ROM order. Each placeholder word is {mode[15], set[14:11], row[10:7], tap[6:4], 4'hA}.
- R7: `wr_addr` bit 7 equals the mode bit, and bits 6:0 are row*8 + tap. Pad slots (tap field at or above the tap count) are never written.
- R8: `busy` is high from the cycle after an accepted start until `done`. `done` is a one-cycle pulse in the cycle after the last write, when `busy` falls. `wr_en` is only high while `busy` is high.
- R9: A `start` pulse while `busy` is high is ignored: the running copy and its set are unchanged and no second copy follows.
- R10: `pend_h`/`pend_v` rise with `done` for the mode just copied. Each clears on its own acknowledge (`ack_h`/`ack_v`) and ignores the other mode's acknowledge.
- R11: After reset `busy`, `done`, `wr_en`, `pend_h` and `pend_v` are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to load a set |
| mode_v | input | 1 | 0 horizontal, 1 vertical |
| src_size | input | SIZE_W | Source width or height |
| dst_size | input | SIZE_W | Destination width or height |
| ack_h | input | 1 | Consumer has taken the horizontal set |
| ack_v | input | 1 | Consumer has taken the vertical set |
| busy | output | 1 | Load in progress |
| done | output | 1 | One-cycle end-of-copy pulse |
| pend_h | output | 1 | Horizontal coefficients waiting to be loaded |
| pend_v | output | 1 | Vertical coefficients waiting to be loaded |
| wr_en | output | 1 | Coefficient memory write enable |
| wr_addr | output | 8 | Bank bit and row/tap slot |
| wr_data | output | COEF_W | Coefficient word |

## Verification
The bench builds the block with its defaults: 12-bit sizes, eight phases, seven horizontal and five vertical taps on a stride of eight, and 16-bit words. The 12-bit sizes let random ratios reach every set from 0 to 9, including the clamp at eight sixteenths and ratios that need both horizontal doublings. The two tap counts leave pad gaps of one and three slots, so a wrong address skip shows in either bank.

// File: rtl/coeff_ld_pkg.sv
package coeff_ld_pkg;

  localparam int NUM_SETS       = 10;
  localparam int SET_W          = 4;
  localparam int SET_UP         = 0;
  localparam int SET_UNITY      = 1;
  localparam int SET_RATIO_BASE = 2;
  localparam int RATIO_FLOOR    = 8;

  typedef enum logic {BANK_H = 1'b0, BANK_V = 1'b1} bank_e;

  // Placeholder coefficient: its own origin packed into the word.
  function automatic logic [15:0] make_word(input logic bank, input int set,
                                            input int row, input int tap);
    logic [3:0] s4;
    logic [3:0] r4;
    logic [2:0] t3;
    s4 = 4'(set);
    r4 = 4'(row);
    t3 = 3'(tap);
    return {bank, s4, r4, t3, 4'hA};
  endfunction

endpackage

// File: rtl/seq_divider.sv
module seq_divider #(
  parameter int NUM_W = 16,
  parameter int DEN_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic             done,
  output logic [NUM_W-1:0] quo
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q;
  logic [DEN_W-1:0] den_q;
  logic [NUM_W-1:0] sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic [DEN_W:0]   trial;
  logic [DEN_W:0]   diff;
  logic             fits;

  always_comb begin
    trial = {rem_q, sh_q[NUM_W-1]};
    fits  = trial >= {1'b0, den_q};
    diff  = trial - {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      done  <= 1'b0;
      rem_q <= '0;
      den_q <= '0;
      sh_q  <= '0;
      cnt_q <= '0;
    end else begin
      done <= 1'b0;
      if (go) begin
        rem_q <= '0;
        den_q <= den;
        sh_q  <= num;
        cnt_q <= CNT_W'(NUM_W);
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        sh_q  <= {sh_q[NUM_W-2:0], fits};
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end

  assign quo = sh_q;

  // R4: the remainder left by the divider is below the divisor
  a_r4_rem_below_den: assert property (@(posedge clk) disable iff (rst)
    done |-> (rem_q < den_q));

endmodule

// File: rtl/coeff_idx_sel.sv
module coeff_idx_sel
  import coeff_ld_pkg::*;
#(
  parameter int SIZE_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             go,
  input  logic             mode_v,
  input  logic [SIZE_W-1:0] src,
  input  logic [SIZE_W-1:0] dst,
  output logic             idx_vld,
  output logic [SET_W-1:0] idx,
  output logic             idx_mode
);
  localparam int NUM_W = SIZE_W + 4;

  typedef enum logic [1:0] {S_IDLE, S_ADJ, S_DIV} sel_st_e;

  sel_st_e          st_q;
  logic             mode_q;
  logic [SIZE_W-1:0] src_q;
  logic [SIZE_W-1:0] dst_q;
  logic [SIZE_W:0]  d0, dbl1, d1, dbl2, d2;
  logic [SIZE_W-1:0] dadj;
  logic             up, eq;
  logic             div_go, div_done;
  logic [NUM_W-1:0] quo;
  logic [SET_W-1:0] sixt;

  // Decimation compensation in horizontal mode only (R2, R5).
  always_comb begin
    d0   = {1'b0, dst_q};
    dbl1 = {d0[SIZE_W-1:0], 1'b0};
    d1   = (!mode_q && (dbl1 < {1'b0, src_q})) ? dbl1 : d0;
    dbl2 = {d1[SIZE_W-1:0], 1'b0};
    d2   = (!mode_q && (dbl2 < {1'b0, src_q})) ? dbl2 : d1;
    dadj = d2[SIZE_W-1:0];
    up   = dst_q > src_q;
    eq   = dadj == src_q;
    div_go = (st_q == S_ADJ) && !up && !eq;
    sixt = (quo < NUM_W'(RATIO_FLOOR)) ? SET_W'(RATIO_FLOOR) : quo[SET_W-1:0];
  end

  seq_divider #(.NUM_W(NUM_W), .DEN_W(SIZE_W)) u_div (
    .clk  (clk),
    .rst  (rst),
    .go   (div_go),
    .num  ({dadj, 4'b0000}),
    .den  (src_q),
    .done (div_done),
    .quo  (quo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= S_IDLE;
      mode_q   <= 1'b0;
      src_q    <= '0;
      dst_q    <= '0;
      idx_vld  <= 1'b0;
      idx      <= '0;
      idx_mode <= 1'b0;
    end else begin
      idx_vld <= 1'b0;
      case (st_q)
        S_IDLE: if (go) begin
          mode_q <= mode_v;
          src_q  <= src;
          dst_q  <= dst;
          st_q   <= S_ADJ;
        end
        S_ADJ: begin
          idx_mode <= mode_q;
          if (up) begin
            idx     <= SET_W'(SET_UP);
            idx_vld <= 1'b1;
            st_q    <= S_IDLE;
          end else if (eq) begin
            idx     <= SET_W'(SET_UNITY);
            idx_vld <= 1'b1;
            st_q    <= S_IDLE;
          end else begin
            st_q <= S_DIV;
          end
        end
        S_DIV: if (div_done) begin
          idx     <= sixt - SET_W'(RATIO_FLOOR - SET_RATIO_BASE);
          idx_vld <= 1'b1;
          st_q    <= S_IDLE;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // R4: every chosen set lies inside the ROM
  a_r4_idx_in_rom: assert property (@(posedge clk) disable iff (rst)
    idx_vld |-> (idx < SET_W'(NUM_SETS)));

  // R1: an enlargement resolves to the up-scale set on the next cycle
  a_r1_up_set: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_ADJ && dst_q > src_q) |=> (idx_vld && idx == SET_W'(SET_UP)));

endmodule

// File: rtl/coeff_rom.sv
module coeff_rom
  import coeff_ld_pkg::*;
#(
  parameter int    TAPS   = 7,
  parameter int    ROWS   = 16,
  parameter int    AW     = 11,
  parameter int    COEF_W = 16,
  parameter bank_e BANK   = BANK_H
) (
  input  logic              clk,
  input  logic [AW-1:0]     addr,
  output logic [COEF_W-1:0] q
);
  localparam int PER_SET = ROWS * TAPS;

  function automatic logic [COEF_W-1:0] word_at(input logic [AW-1:0] a);
    int ai;
    ai = int'(a);
    return COEF_W'(make_word(BANK, ai / PER_SET, (ai / TAPS) % ROWS, ai % TAPS));
  endfunction

  // Registered read, one cycle latency.
  always_ff @(posedge clk) begin
    q <= word_at(addr);
  end

endmodule

// File: rtl/coeff_copy_seq.sv
module coeff_copy_seq
  import coeff_ld_pkg::*;
#(
  parameter int ROWS    = 16,
  parameter int H_TAPS  = 7,
  parameter int V_TAPS  = 5,
  parameter int STRIDE  = 8,
  parameter int COEF_W  = 16,
  parameter int ROM_AW  = 11,
  parameter int MEM_AW  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic [SET_W-1:0]  set,
  input  logic              mode,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [COEF_W-1:0] rom_q_h,
  input  logic [COEF_W-1:0] rom_q_v,
  output logic              wr_en,
  output logic [MEM_AW-1:0] wr_addr,
  output logic [COEF_W-1:0] wr_data,
  output logic              wr_last
);
  localparam int ROW_W  = $clog2(ROWS);
  localparam int TAP_W  = $clog2(STRIDE);
  localparam int SLOT_W = MEM_AW - 1;

  logic              run_q;
  logic              mode_q;
  logic [ROW_W-1:0]  row_q;
  logic [TAP_W-1:0]  tap_q;
  logic [SLOT_W-1:0] wptr_q;
  logic [TAP_W-1:0]  tap_last;
  logic              elem_last;
  logic              p_vld, p_last, p_mode;
  logic [MEM_AW-1:0] p_addr;

  always_comb begin
    tap_last  = mode_q ? TAP_W'(V_TAPS - 1) : TAP_W'(H_TAPS - 1);
    elem_last = (row_q == ROW_W'(ROWS - 1)) && (tap_q == tap_last);
  end

  // Read side: walk the ROM linearly and the memory on a padded stride.
  always_ff @(posedge clk) begin
    if (rst) begin
      run_q    <= 1'b0;
      mode_q   <= 1'b0;
      row_q    <= '0;
      tap_q    <= '0;
      wptr_q   <= '0;
      rom_addr <= '0;
      p_vld    <= 1'b0;
      p_last   <= 1'b0;
      p_mode   <= 1'b0;
      p_addr   <= '0;
    end else begin
      p_vld <= 1'b0;
      if (go && !run_q) begin
        run_q    <= 1'b1;
        mode_q   <= mode;
        row_q    <= '0;
        tap_q    <= '0;
        wptr_q   <= '0;
        rom_addr <= ROM_AW'(int'(set) * ROWS * (mode ? V_TAPS : H_TAPS));
      end else if (run_q) begin
        p_vld    <= 1'b1;
        p_last   <= elem_last;
        p_mode   <= mode_q;
        p_addr   <= {mode_q, wptr_q};
        rom_addr <= rom_addr + 1'b1;
        if (tap_q == tap_last) begin
          tap_q  <= '0;
          row_q  <= row_q + 1'b1;
          wptr_q <= wptr_q + SLOT_W'(STRIDE) - SLOT_W'(tap_last);
        end else begin
          tap_q  <= tap_q + 1'b1;
          wptr_q <= wptr_q + 1'b1;
        end
        if (elem_last) run_q <= 1'b0;
      end
    end
  end

  // Write side: ROM data arrives with the p_* stage, registered out.
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_en   <= 1'b0;
      wr_last <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en   <= p_vld;
      wr_last <= p_vld && p_last;
      wr_addr <= p_addr;
      wr_data <= p_mode ? rom_q_v : rom_q_h;
    end
  end

  // R7: no write lands in a row's padding
  a_r7_no_pad_write: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_addr[TAP_W-1:0] <
               (wr_addr[MEM_AW-1] ? TAP_W'(V_TAPS) : TAP_W'(H_TAPS))));

  // R9: a new set is never taken while a copy runs
  a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
    (run_q && !elem_last) |=> run_q);

endmodule

// File: rtl/coeff_loader.sv
module coeff_loader
  import coeff_ld_pkg::*;
#(
  parameter int SIZE_W     = 12,
  parameter int NUM_PHASES = 8,
  parameter int H_TAPS     = 7,
  parameter int V_TAPS     = 5,
  parameter int STRIDE     = 8,
  parameter int COEF_W     = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode_v,
  input  logic [SIZE_W-1:0] src_size,
  input  logic [SIZE_W-1:0] dst_size,
  input  logic              ack_h,
  input  logic              ack_v,
  output logic              busy,
  output logic              done,
  output logic              pend_h,
  output logic              pend_v,
  output logic              wr_en,
  output logic [$clog2(2*NUM_PHASES*STRIDE):0] wr_addr,
  output logic [COEF_W-1:0] wr_data
);
  localparam int ROWS     = 2 * NUM_PHASES;
  localparam int MAX_TAPS = (H_TAPS > V_TAPS) ? H_TAPS : V_TAPS;
  localparam int ROM_AW   = $clog2(NUM_SETS * ROWS * MAX_TAPS);
  localparam int MEM_AW   = $clog2(ROWS * STRIDE) + 1;

  logic              go;
  logic              idx_vld, idx_mode;
  logic [SET_W-1:0]  idx;
  logic [ROM_AW-1:0] rom_addr;
  logic [COEF_W-1:0] rom_q [2];
  logic              wr_last;
  logic              last_wr;
  logic              last_bank_v;

  assign go = start && !busy;

  coeff_idx_sel #(.SIZE_W(SIZE_W)) u_sel (
    .clk      (clk),
    .rst      (rst),
    .go       (go),
    .mode_v   (mode_v),
    .src      (src_size),
    .dst      (dst_size),
    .idx_vld  (idx_vld),
    .idx      (idx),
    .idx_mode (idx_mode)
  );

  for (genvar b = 0; b < 2; b++) begin : g_rom
    coeff_rom #(
      .TAPS   (b == 0 ? H_TAPS : V_TAPS),
      .ROWS   (ROWS),
      .AW     (ROM_AW),
      .COEF_W (COEF_W),
      .BANK   (b == 0 ? BANK_H : BANK_V)
    ) u_rom (
      .clk  (clk),
      .addr (rom_addr),
      .q    (rom_q[b])
    );
  end

  coeff_copy_seq #(
    .ROWS   (ROWS),
    .H_TAPS (H_TAPS),
    .V_TAPS (V_TAPS),
    .STRIDE (STRIDE),
    .COEF_W (COEF_W),
    .ROM_AW (ROM_AW),
    .MEM_AW (MEM_AW)
  ) u_copy (
    .clk      (clk),
    .rst      (rst),
    .go       (idx_vld),
    .set      (idx),
    .mode     (idx_mode),
    .rom_addr (rom_addr),
    .rom_q_h  (rom_q[0]),
    .rom_q_v  (rom_q[1]),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .wr_last  (wr_last)
  );

  assign last_wr     = wr_en && wr_last;
  assign last_bank_v = wr_addr[MEM_AW-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      done   <= 1'b0;
      pend_h <= 1'b0;
      pend_v <= 1'b0;
    end else begin
      done <= last_wr;
      if (go)           busy <= 1'b1;
      else if (last_wr) busy <= 1'b0;
      if (last_wr && !last_bank_v) pend_h <= 1'b1;
      else if (ack_h)              pend_h <= 1'b0;
      if (last_wr && last_bank_v)  pend_v <= 1'b1;
      else if (ack_v)              pend_v <= 1'b0;
    end
  end

  // R8: done coincides with busy having fallen
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R8: writes only happen inside a busy window
  a_r8_write_in_busy: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> busy);

  // R8: done lasts a single cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R9: start while busy keeps the block busy
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (rst)
    (start && busy && !last_wr) |=> busy);

  // R10: an acknowledge clears only its own flag
  a_r10_ack_h_clears: assert property (@(posedge clk) disable iff (rst)
    (ack_h && !(last_wr && !last_bank_v)) |=> !pend_h);

  a_r10_ack_v_keeps_h: assert property (@(posedge clk) disable iff (rst)
    (pend_h && !ack_h) |=> pend_h);

endmodule

// File: tb/tb_coeff_loader.sv
module tb_coeff_loader;

  logic        clk = 1'b0;
  logic        rst;
  logic        start, mode_v, ack_h, ack_v;
  logic [11:0] src_size, dst_size;
  logic        busy, done, pend_h, pend_v, wr_en;
  logic [7:0]  wr_addr;
  logic [15:0] wr_data;

  int n_checks = 0;
  int n_fail   = 0;
  int n_wr     = 0;
  int cycles   = 0;
  logic [7:0]  wa [256];
  logic [15:0] wd [256];

  always #4 clk = ~clk;

  coeff_loader dut (
    .clk(clk), .rst(rst), .start(start), .mode_v(mode_v),
    .src_size(src_size), .dst_size(dst_size), .ack_h(ack_h), .ack_v(ack_v),
    .busy(busy), .done(done), .pend_h(pend_h), .pend_v(pend_v),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always @(negedge clk) begin
    if (wr_en) begin
      if (n_wr < 256) begin
        wa[n_wr] = wr_addr;
        wd[n_wr] = wr_data;
      end
      n_wr++;
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not finish, actual %0d cycles expected < 190000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int exp_set(input bit m, input int s, input int d);
    int dd, six;
    if (d > s) return 0;
    dd = d;
    if (!m) begin
      if (2 * dd < s) dd = 2 * dd;
      if (2 * dd < s) dd = 2 * dd;
    end
    if (dd == s) return 1;
    six = (dd * 16) / s;
    if (six < 8) six = 8;
    return 2 + six - 8;
  endfunction

  function automatic string set_req(input bit m, input int s, input int d);
    if (d > s) return "R1";
    if (d == s) return "R3";
    if (!m && 2 * d < s) return "R2/R4";
    if (m) return "R5/R4";
    return "R4";
  endfunction

  task automatic pulse_start(input bit m, input int s, input int d);
    @(negedge clk);
    start = 1'b1; mode_v = m; src_size = 12'(s); dst_size = 12'(d);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_case(input bit m, input int s, input int d, input bit poke);
    int taps, set, k, got;
    bit ok_a, ok_d;
    n_wr = 0;
    taps = m ? 5 : 7;
    set  = exp_set(m, s, d);
    pulse_start(m, s, d);
    chk(busy == 1'b1, "R8", "busy after start", int'(busy), 1);
    if (poke) begin
      repeat (30) @(negedge clk);
      pulse_start(~m, 100, 200);   // R9: must be ignored
    end
    k = 0;
    while (done !== 1'b1 && k < 3000) begin
      @(negedge clk);
      k++;
    end
    chk(done === 1'b1, "R8", "done seen", int'(done), 1);
    chk(busy == 1'b0, "R8", "busy low at done", int'(busy), 0);
    chk((m ? pend_v : pend_h) == 1'b1, "R10", "pending raised", 0, 1);
    chk(n_wr == 16 * taps, "R6", "write count", n_wr, 16 * taps);
    got = (n_wr > 0) ? int'(wd[0][14:11]) : -1;
    chk(got == set, set_req(m, s, d), "set index", got, set);
    ok_a = 1'b1; ok_d = 1'b1;
    for (int i = 0; i < 16 * taps && i < n_wr; i++) begin
      int row, tap;
      row = i / taps; tap = i % taps;
      if (wa[i] != {m, 7'(row * 8 + tap)}) ok_a = 1'b0;
      if (wd[i] != {m, 4'(set), 4'(row), 3'(tap), 4'hA}) ok_d = 1'b0;
    end
    chk(ok_a, "R7", "address pattern", 0, 1);
    chk(ok_d, "R6", "data order", 0, 1);
    repeat (40) @(negedge clk);
    chk(n_wr == 16 * taps, "R9", "no writes after done", n_wr, 16 * taps);
    chk(busy == 1'b0, "R9", "stays idle", int'(busy), 0);
    // R10: other mode's ack leaves the flag, own ack clears it
    if (m) ack_h = 1'b1; else ack_v = 1'b1;
    @(negedge clk);
    ack_h = 1'b0; ack_v = 1'b0;
    chk((m ? pend_v : pend_h) == 1'b1, "R10", "other ack ignored", 0, 1);
    if (m) ack_v = 1'b1; else ack_h = 1'b1;
    @(negedge clk);
    ack_h = 1'b0; ack_v = 1'b0;
    chk((m ? pend_v : pend_h) == 1'b0, "R10", "own ack clears", 1, 0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; start = 1'b0; mode_v = 1'b0; ack_h = 1'b0; ack_v = 1'b0;
    src_size = '0; dst_size = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(busy == 0 && done == 0 && wr_en == 0, "R11", "idle after reset",
        int'({busy, done, wr_en}), 0);
    chk(pend_h == 0 && pend_v == 0, "R11", "flags after reset",
        int'({pend_h, pend_v}), 0);

    run_case(1'b0, 100, 200, 1'b0);   // R1 horizontal up
    run_case(1'b1, 640, 641, 1'b0);   // R1 vertical up
    run_case(1'b0, 300, 300, 1'b0);   // R3 unity
    run_case(1'b1, 300, 300, 1'b0);   // R3 1:1
    run_case(1'b0, 0, 0, 1'b0);       // R3 zero sizes
    run_case(1'b0, 1000, 100, 1'b0);  // R2 two doublings, clamp
    run_case(1'b0, 100, 30, 1'b0);    // R2 one doubling
    run_case(1'b1, 100, 30, 1'b0);    // R5 no doubling, clamp
    run_case(1'b1, 100, 99, 1'b0);    // R4 top set
    run_case(1'b0, 100, 60, 1'b1);    // R9 poke while busy
    run_case(1'b1, 4095, 2048, 1'b1); // R9 vertical

    for (int n = 0; n < 40; n++) begin
      int s, d;
      bit m;
      m = 1'($urandom);
      s = 1 + int'($urandom % 4095);
      d = 1 + int'($urandom % 4095);
      run_case(m, s, d, 1'($urandom % 4 == 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule